// File: doc/BRIEF.md
# Serial Line Auto-Baud Detector with Lock Handshake

This block listens on an asynchronous serial receive line straight after reset and works out how fast the host is sending. During detection the host keeps sending the byte 0x00 in 8N1 framing (8 data bits, 1 stop bit, no parity). Each such byte holds the line low for exactly nine bit times: the start bit followed by eight zero data bits. Then comes at least one bit time of high line. The block counts system clocks across each low run. It divides the count by nine, rounding to nearest, to get a bit-period divisor in clocks.

A first byte may be caught partway through. To guard against that, the block accepts a divisor only after two consecutive low runs that agree within about 3 percent. It then uses the divisor for a minimal 8N1 transmitter and receiver. First it sends a single 0x00 byte back as the end-of-adjustment signal. Then it waits for one byte from the host. A correctly framed 0x55 locks the block and raises `done`. Any other byte, or a low stop bit, raises `error`. Both outcomes are terminal, and the only way to try again is a full reset followed by a new detection.

Top module: `autobaud_lock`

## Requirements
- R1: While reset is held and just after it is released, `tx` is 1, `done` and `error` are 0 and `divisor` is 0.
- R2: Low runs are measured in clocks on the synchronized line. An accepted run of L clocks sets `divisor` to round(L/9), where a remainder of 5 or more rounds up. Once non-zero, `divisor` does not change until reset.
- R3: A run is accepted only if the previous run exists and the two differ by at most the previous run shifted right by TOL_SHIFT (default 5). A run that is not accepted becomes the new reference, so a single zero byte never causes a transmission.
- R4: A run shorter than MIN_RUN clocks (default 18) is never accepted, so the divisor is always at least 2.
- R5: A low run that lasts beyond 2^CNT_W-1 clocks is discarded, the reference run is cleared, and detection starts again.
- R6: `tx` stays 1 throughout detection. After acceptance the block sends exactly one frame of 0x00 at the divisor rate. This frame is `tx` low for exactly 9*divisor clocks, then high for at least divisor clocks.
- R7: After that frame the receiver samples the reply, least significant bit first, at divisor/2 clocks after the start-bit falling edge and every divisor clocks after that. A reply of 0x55 with a high stop bit raises `done`.
- R8: A reply other than 0x55, or a reply whose stop bit is sampled low, raises `error` and never `done`. The two flags are never high together.
- R9: `done` and `error` are sticky until reset. Once either is set, further line activity is ignored: `tx` stays 1 and `divisor` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx | input | 1 | Serial receive line from the host (idle high) |
| tx | output | 1 | Serial transmit line to the host (idle high) |
| divisor | output | CNT_W | Derived bit period in clocks; 0 until accepted |
| done | output | 1 | Handshake completed with 0x55 |
| error | output | 1 | Handshake reply wrong or framing bad |

## Verification
The bench sweeps the low-run length in steps that cover every remainder mod nine. A design that truncated instead of rounding, or divided by eight or ten, would report the wrong divisor and send an echo frame of the wrong length. Further cases target acceptance. A short partial first run, a pair of runs one clock outside the tolerance, and runs just under the minimum must all leave `tx` silent. A matcher that trusted the first run, or was off by one at the tolerance edge, would transmit early. The overflow case puts a matching run on each side of an over-long low period. A design that kept its old reference would lock one byte too soon. Wrong replies, a low stop bit, and traffic after lock check that the terminal states neither flip nor transmit again.

// File: rtl/autobaud_lock.sv
module autobaud_lock #(
  parameter int CNT_W     = 17,
  parameter int TOL_SHIFT = 5,
  parameter int MIN_RUN   = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx,
  output logic             tx,
  output logic [CNT_W-1:0] divisor,
  output logic             done,
  output logic             error
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] NINE    = CNT_W'(9);
  localparam logic [CNT_W-1:0] RND_UP  = CNT_W'(5);
  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(MIN_RUN);
  localparam logic [9:0]       ECHO    = {1'b1, 8'h00, 1'b0};

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_TX, S_RXW, S_RX, S_DONE, S_ERR} state_t;

  state_t           state;
  logic [1:0]       sync;
  logic             rx_d;
  logic [CNT_W-1:0] cnt, ref_run, timer;
  logic             have_ref;
  logic [3:0]       bits;
  logic [9:0]       sh;

  wire rx_q = sync[1];
  wire fall = rx_d & ~rx_q;
  wire rise = ~rx_d & rx_q;

  wire [CNT_W-1:0] diff    = (cnt >= ref_run) ? cnt - ref_run : ref_run - cnt;
  wire             agree   = have_ref && (diff <= (ref_run >> TOL_SHIFT)) && (cnt >= MIN_LEN);
  wire [CNT_W-1:0] quot    = cnt / NINE;
  wire [CNT_W-1:0] rem     = cnt % NINE;
  wire [CNT_W-1:0] rounded = quot + ((rem >= RND_UP) ? ONE : '0);
  wire [CNT_W-1:0] half    = divisor >> 1;
  wire             tick    = (timer == '0);

  assign done  = (state == S_DONE);
  assign error = (state == S_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      rx_d <= 1'b1;
    end else begin
      sync <= {sync[0], rx};
      rx_d <= rx_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      ref_run  <= '0;
      have_ref <= 1'b0;
      divisor  <= '0;
      timer    <= '0;
      bits     <= '0;
      sh       <= '0;
      tx       <= 1'b1;
    end else begin
      case (state)
        S_IDLE: if (fall) begin
          cnt   <= ONE;
          state <= S_LOW;
        end
        S_LOW: begin
          if (rise) begin
            if (agree) begin
              divisor <= rounded;
              tx      <= ECHO[0];
              sh      <= ECHO >> 1;
              bits    <= 4'd9;
              timer   <= rounded - ONE;
              state   <= S_TX;
            end else begin
              ref_run  <= cnt;
              have_ref <= 1'b1;
              state    <= S_IDLE;
            end
          end else if (cnt == CNT_MAX) begin
            have_ref <= 1'b0;
            state    <= S_IDLE;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        S_TX: begin
          if (tick) begin
            if (bits == 4'd0) begin
              state <= S_RXW;
            end else begin
              tx    <= sh[0];
              sh    <= sh >> 1;
              bits  <= bits - 4'd1;
              timer <= divisor - ONE;
            end
          end else begin
            timer <= timer - ONE;
          end
        end
        S_RXW: if (fall) begin
          timer <= half - ONE;
          bits  <= 4'd9;
          state <= S_RX;
        end
        S_RX: begin
          if (tick) begin
            sh    <= {rx_q, sh[9:1]};
            timer <= divisor - ONE;
            if (bits == 4'd9 && rx_q) begin
              state <= S_RXW;
            end else if (bits == 4'd0) begin
              state <= (rx_q && sh[9:2] == 8'h55) ? S_DONE : S_ERR;
            end else begin
              bits <= bits - 4'd1;
            end
          end else begin
            timer <= timer - ONE;
          end
        end
        default: state <= state;
      endcase
    end
  end

endmodule

module autobaud_lock_chk #(
  parameter int CNT_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx,
  input logic [CNT_W-1:0] divisor,
  input logic             done,
  input logic             error
);

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (tx && !done && !error && divisor == '0)); // R1
  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n) (divisor != '0) |=> (divisor == $past(divisor))); // R2
  AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n) (divisor != '0) |-> (divisor >= CNT_W'(2))); // R4
  AST_TX_NEEDS_DIV: assert property (@(posedge clk) disable iff (!rst_n) !tx |-> (divisor != '0)); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && error)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done |=> done); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) error |=> error); // R9
  AST_LOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (done || error) |-> tx); // R9
  AST_LOCKED_DIV: assert property (@(posedge clk) disable iff (!rst_n) (done || error) |=> $stable(divisor)); // R9

endmodule

bind autobaud_lock autobaud_lock_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx(tx), .divisor(divisor), .done(done), .error(error)
);

// File: tb/autobaud_lock_test.sv
module autobaud_lock_test;
  localparam int CNT_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic tx, done, error;
  logic [CNT_W-1:0] divisor;

  int checks = 0;
  int errors = 0;
  int tx_falls = 0, tx_run = 0, tx_last = 0;

  always #5 clk = ~clk;

  autobaud_lock #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .rx(rx), .tx(tx),
    .divisor(divisor), .done(done), .error(error)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      tx_falls <= 0; tx_run <= 0; tx_last <= 0;
    end else if (!tx) begin
      if (tx_run == 0) tx_falls <= tx_falls + 1;
      tx_run <= tx_run + 1;
    end else if (tx_run != 0) begin
      tx_last <= tx_run;
      tx_run <= 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    rx = v;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rx = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    drive(1'b1, 4);
  endtask

  task automatic zero_byte(input int len);
    drive(1'b0, len);
    drive(1'b1, len / 9 + 6);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic stopb, input int d);
    drive(1'b0, d);
    for (int i = 0; i < 8; i++) drive(b[i], d);
    drive(stopb, d);
    drive(1'b1, 2 * d + 5);
  endtask

  task automatic wait_echo(input int d);
    repeat (10 * d + 10) @(posedge clk);
    #1;
  endtask

  task automatic run_case(input int len, input logic [7:0] b, input logic stopb, input int exp_done);
    int ed;
    ed = (len + 4) / 9;
    do_reset();
    zero_byte(len);
    @(negedge clk);
    check("R3 single run no echo", tx_falls, 0);
    zero_byte(len);
    wait_echo(ed);
    @(negedge clk);
    check("R6 one echo frame", tx_falls, 1);
    check("R6 echo low length", tx_last, 9 * ed);
    check("R2 divisor rounding", int'(divisor), ed);
    send_byte(b, stopb, ed);
    @(negedge clk);
    check(exp_done ? "R7 done after 0x55" : "R8 done stays low", int'(done), exp_done);
    check(exp_done ? "R7 no error" : "R8 error raised", int'(error), exp_done ? 0 : 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 tx in reset", int'(tx), 1);
    check("R1 divisor in reset", int'(divisor), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 tx", int'(tx), 1);
    check("R1 done", int'(done), 0);
    check("R1 error", int'(error), 0);
    check("R1 divisor", int'(divisor), 0);

    // R2 R6 R7 sweep over run lengths (all remainders mod 9)
    for (int len = 18; len <= 420; len += 11) run_case(len, 8'h55, 1'b1, 1);

    // R3 partial first byte
    do_reset();
    zero_byte(90);
    zero_byte(200);
    @(negedge clk);
    check("R3 partial then full no echo", tx_falls, 0);
    zero_byte(200);
    wait_echo(22);
    @(negedge clk);
    check("R3 accept after agreement", int'(divisor), 22);

    // R3 tolerance boundary: 331 vs 320 is one outside, 341 vs 331 is at the edge
    do_reset();
    zero_byte(320);
    zero_byte(331);
    @(negedge clk);
    check("R3 outside tolerance", tx_falls, 0);
    zero_byte(341);
    wait_echo(38);
    @(negedge clk);
    check("R3 at tolerance edge", int'(divisor), 38);
    check("R3 echo sent", tx_falls, 1);

    // R4 short runs never accepted
    do_reset();
    zero_byte(17);
    zero_byte(17);
    zero_byte(17);
    @(negedge clk);
    check("R4 short runs no echo", tx_falls, 0);
    check("R4 short runs divisor", int'(divisor), 0);

    // R5 overflow clears the reference
    do_reset();
    zero_byte(300);
    drive(1'b0, 1100);
    drive(1'b1, 40);
    zero_byte(300);
    @(negedge clk);
    check("R5 overflow cleared reference", tx_falls, 0);
    zero_byte(300);
    wait_echo(33);
    @(negedge clk);
    check("R5 detection restarted", int'(divisor), 33);

    // R8 wrong replies and framing
    run_case(180, 8'h54, 1'b1, 0);
    run_case(180, 8'hD5, 1'b1, 0);
    run_case(180, 8'h55, 1'b0, 0);

    // R9 error is terminal
    zero_byte(180);
    zero_byte(180);
    send_byte(8'h55, 1'b1, 20);
    @(negedge clk);
    check("R9 error sticky", int'(error), 1);
    check("R9 no done after error", int'(done), 0);
    check("R9 no echo after error", tx_falls, 1);
    check("R9 divisor held after error", int'(divisor), 20);

    // R9 done is terminal
    run_case(200, 8'h55, 1'b1, 1);
    zero_byte(200);
    zero_byte(200);
    send_byte(8'h00, 1'b1, 22);
    @(negedge clk);
    check("R9 done sticky", int'(done), 1);
    check("R9 no error after done", int'(error), 0);
    check("R9 no echo after done", tx_falls, 1);
    check("R9 divisor held after done", int'(divisor), 22);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule